// File: doc/BRIEF.md
# Arbitrated Dual-Port RAM with Mailbox Flags

A synchronous 2048 x 8 memory reached through two independent ports, called left and right. Each port has its own address, write-data and read-data buses and its own active-low chip enable, read/write select and active-low output enable. Any two ports can reach any location. When both ports reach the same word in the same cycle and at least one of them writes, arbitration picks a winner. The loser sees its BUSY flag raised, and any write it attempts in that cycle is dropped.

Two words at the top of the address space act as mailboxes. When one port writes its partner's mailbox word, the partner's interrupt flag rises. The flag drops when the partner reads that word. For width expansion a device can run as a slave. In that mode the BUSY lines are taken from inputs driven by a master device, and the local collision decision is not used. This keeps the write-blocking decisions of all slices in step.

Top module: `dpram_arb`

## Requirements
- R1: A read with chip enable low and the read/write select high (1 = read, 0 = write) samples the address at a clock edge. The stored word then appears on that port's read data after that edge. A write with chip enable low and the select low stores write data at the edge.
- R2: A port's read data is zero while its output enable is high. It is also zero after an edge at which the port was writing or had chip enable high.
- R3: Both ports reading the same address in the same cycle raise no BUSY, and both receive the stored word.
- R4: In master mode, suppose both ports address the same word in one cycle, at least one of them writes, and neither was already holding that word. Then left wins. Right BUSY is high for that cycle, and a right write is dropped, leaving the memory unchanged.
- R5: In master mode, suppose one port had chip enable low on the same address in the previous cycle and the other port did not. That incumbent port wins a collision on this address. BUSY goes to the newcomer, and the newcomer's write is dropped.
- R6: A right-port write to address 0x7FF (that is not blocked) sets the left interrupt flag one edge later. A left-port read of 0x7FF clears it. A left-port write to 0x7FF does not set it. If a set and a clear fall on the same edge, the set wins.
- R7: A left-port write to address 0x7FE (that is not blocked) sets the right interrupt flag. A right-port read of 0x7FE clears it. If a set and a clear fall on the same edge, the set wins.
- R8: With the slave select high, each BUSY output equals its BUSY input, whatever the addresses are. A write from a port whose BUSY input is high is dropped.
- R9: A port with chip enable high writes nothing. It never has BUSY raised in master mode, and it takes no part in collisions.
- R10: Suppose right reads a word in the same cycle that left writes it. Left's write lands, and right's read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_en | input | 1 | 1: BUSY taken from the inputs; 0: local arbitration |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw | input | 1 | Left select, 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 11 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data |
| l_busy_in | input | 1 | Left BUSY from a master (slave mode) |
| l_busy | output | 1 | Left BUSY |
| l_int | output | 1 | Left mailbox interrupt flag |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw | input | 1 | Right select, 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 11 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data |
| r_busy_in | input | 1 | Right BUSY from a master (slave mode) |
| r_busy | output | 1 | Right BUSY |
| r_int | output | 1 | Right mailbox interrupt flag |

## Verification
The assertions check the following on every cycle:
- BUSY is never raised on both ports at once, and a write collision in master mode always yields exactly one BUSY.
- A read-read match is always free of BUSY, and a disabled port is never busy.
- Slave BUSY follows its inputs.
- Mailbox flags rise after an unblocked write to the partner's word.
- Read data is zero after a write edge.

Only the directed scenarios show the following, because they need memory contents or history across several cycles:
- That a dropped write really left the old word in place.
- That the incumbent beats the newcomer.
- That a colliding read returns the pre-write word.
- That reads clear the flags.

// File: rtl/dpram_arb.sv
module dpram_arb #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_en,
  input  logic          l_ce_n,
  input  logic          l_rw,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          l_busy_in,
  output logic          l_busy,
  output logic          l_int,
  input  logic          r_ce_n,
  input  logic          r_rw,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  input  logic          r_busy_in,
  output logic          r_busy,
  output logic          r_int
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] L_MBOX = AW'(DEPTH - 1);
  localparam logic [AW-1:0] R_MBOX = AW'(DEPTH - 2);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] l_q, r_q;
  logic [AW-1:0] l_prev_addr, r_prev_addr;
  logic          l_prev_act, r_prev_act;

  logic l_act, r_act, l_wr, r_wr, l_rd, r_rd;
  logic collide, l_held, r_held, arb_l, arb_r, l_we, r_we;

  assign l_act = !l_ce_n;
  assign r_act = !r_ce_n;
  assign l_wr  = l_act && !l_rw;
  assign r_wr  = r_act && !r_rw;
  assign l_rd  = l_act && l_rw;
  assign r_rd  = r_act && r_rw;

  assign collide = l_act && r_act && (l_addr == r_addr) && (l_wr || r_wr);
  assign l_held  = l_prev_act && (l_prev_addr == l_addr);
  assign r_held  = r_prev_act && (r_prev_addr == r_addr);
  assign arb_l   = collide && r_held && !l_held;
  assign arb_r   = collide && !arb_l;

  assign l_busy = slave_en ? l_busy_in : arb_l;
  assign r_busy = slave_en ? r_busy_in : arb_r;
  assign l_we   = l_wr && !l_busy;
  assign r_we   = r_wr && !r_busy;

  assign l_rdata = l_oe_n ? '0 : l_q;
  assign r_rdata = r_oe_n ? '0 : r_q;

  always_ff @(posedge clk) begin
    if (l_we) mem[l_addr] <= l_wdata;
    if (r_we) mem[r_addr] <= r_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q         <= '0;
      r_q         <= '0;
      l_prev_act  <= 1'b0;
      r_prev_act  <= 1'b0;
      l_prev_addr <= '0;
      r_prev_addr <= '0;
      l_int       <= 1'b0;
      r_int       <= 1'b0;
    end else begin
      l_q         <= l_rd ? mem[l_addr] : '0;
      r_q         <= r_rd ? mem[r_addr] : '0;
      l_prev_act  <= l_act;
      r_prev_act  <= r_act;
      l_prev_addr <= l_addr;
      r_prev_addr <= r_addr;
      if (r_we && r_addr == L_MBOX)      l_int <= 1'b1;
      else if (l_rd && l_addr == L_MBOX) l_int <= 1'b0;
      if (l_we && l_addr == R_MBOX)      r_int <= 1'b1;
      else if (r_rd && r_addr == R_MBOX) r_int <= 1'b0;
    end
  end
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slave_en,
  input logic          l_ce_n,
  input logic          l_rw,
  input logic [AW-1:0] l_addr,
  input logic [DW-1:0] l_rdata,
  input logic          l_busy_in,
  input logic          l_busy,
  input logic          l_int,
  input logic          r_ce_n,
  input logic          r_rw,
  input logic [AW-1:0] r_addr,
  input logic [DW-1:0] r_rdata,
  input logic          r_busy_in,
  input logic          r_busy,
  input logic          r_int
);
  localparam logic [AW-1:0] L_MBOX = AW'((1 << AW) - 1);
  localparam logic [AW-1:0] R_MBOX = AW'((1 << AW) - 2);

  logic both_on, same;
  assign both_on = !l_ce_n && !r_ce_n;
  assign same    = l_addr == r_addr;

  p_one_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_en |-> !(l_busy && r_busy));
  p_wcol_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_en && both_on && same && (!l_rw || !r_rw)) |-> (l_busy || r_busy));
  p_rr_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_en && both_on && l_rw && r_rw) |-> (!l_busy && !r_busy));
  p_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_en && (l_ce_n || r_ce_n)) |-> (!l_busy && !r_busy));
  p_slave_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slave_en |-> (l_busy == l_busy_in && r_busy == r_busy_in));
  p_lint_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_ce_n && !r_rw && r_addr == L_MBOX && !r_busy) |=> l_int);
  p_rint_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce_n && !l_rw && l_addr == R_MBOX && !l_busy) |=> r_int);
  p_wr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce_n && !l_rw) |=> (l_rdata == '0));
endmodule

bind dpram_arb dpram_arb_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slave_en(slave_en),
  .l_ce_n(l_ce_n), .l_rw(l_rw), .l_addr(l_addr), .l_rdata(l_rdata),
  .l_busy_in(l_busy_in), .l_busy(l_busy), .l_int(l_int),
  .r_ce_n(r_ce_n), .r_rw(r_rw), .r_addr(r_addr), .r_rdata(r_rdata),
  .r_busy_in(r_busy_in), .r_busy(r_busy), .r_int(r_int)
);

// File: tb/dpram_arb_tb.sv
module dpram_arb_tb;
  logic clk = 1'b0, rst_n = 1'b0, slave_en = 1'b0;
  logic l_ce_n = 1'b1, l_rw = 1'b1, l_oe_n = 1'b0, l_busy_in = 1'b0;
  logic r_ce_n = 1'b1, r_rw = 1'b1, r_oe_n = 1'b0, r_busy_in = 1'b0;
  logic [10:0] l_addr = '0, r_addr = '0;
  logic [7:0]  l_wdata = '0, r_wdata = '0, l_rdata, r_rdata;
  logic l_busy, r_busy, l_int, r_int;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dpram_arb u_dut (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en),
    .l_ce_n(l_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_busy_in(l_busy_in),
    .l_busy(l_busy), .l_int(l_int),
    .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_busy_in(r_busy_in),
    .r_busy(r_busy), .r_int(r_int)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drv_l(logic ce_n, logic rw, logic [10:0] a, logic [7:0] d);
    l_ce_n = ce_n; l_rw = rw; l_addr = a; l_wdata = d;
  endtask

  task automatic drv_r(logic ce_n, logic rw, logic [10:0] a, logic [7:0] d);
    r_ce_n = ce_n; r_rw = rw; r_addr = a; r_wdata = d;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    drv_l(1, 1, '0, '0); drv_r(1, 1, '0, '0); step();
  endtask

  task automatic rd_l(logic [10:0] a, int exp, string req);
    drv_l(0, 1, a, '0); step(); chk(req, l_rdata, exp); idle();
  endtask

  task automatic rd_r(logic [10:0] a, int exp, string req);
    drv_r(0, 1, a, '0); step(); chk(req, r_rdata, exp); idle();
  endtask

  task automatic t_reset();
    chk("R2 reset l_rdata", l_rdata, 0);
    chk("R2 reset r_rdata", r_rdata, 0);
    chk("R6 reset l_int", l_int, 0);
    chk("R7 reset r_int", r_int, 0);
    chk("R9 reset busy", {l_busy, r_busy}, 0);
  endtask

  task automatic t_basic();
    drv_l(0, 0, 11'h010, 8'hA5); drv_r(0, 0, 11'h020, 8'h3C); #1;
    chk("R1 distinct writes no busy", {l_busy, r_busy}, 0);
    step(); idle();
    drv_l(0, 1, 11'h020, '0); drv_r(0, 1, 11'h010, '0); step();
    chk("R1 left reads right's word", l_rdata, 8'h3C);
    chk("R1 right reads left's word", r_rdata, 8'hA5);
    idle();
  endtask

  task automatic t_zero();
    l_oe_n = 1; drv_l(0, 1, 11'h010, '0); step();
    chk("R2 oe high zero", l_rdata, 0);
    l_oe_n = 0; #1;
    chk("R2 oe low shows data", l_rdata, 8'hA5);
    drv_l(1, 1, 11'h010, '0); step();
    chk("R2 ce high zero", l_rdata, 0);
    drv_l(0, 0, 11'h011, 8'h5A); step();
    chk("R2 write cycle zero", l_rdata, 0);
    idle();
    drv_r(1, 0, 11'h010, 8'hFF); drv_l(0, 0, 11'h010, 8'hA5); #1;
    chk("R9 disabled port no busy", {l_busy, r_busy}, 0);
    step(); idle();
    rd_l(11'h010, 8'hA5, "R9 disabled write ignored");
  endtask

  task automatic t_rr();
    drv_l(0, 1, 11'h010, '0); drv_r(0, 1, 11'h010, '0); #1;
    chk("R3 same-address reads no busy", {l_busy, r_busy}, 0);
    step();
    chk("R3 left data", l_rdata, 8'hA5);
    chk("R3 right data", r_rdata, 8'hA5);
    idle();
  endtask

  task automatic t_wcol();
    drv_l(0, 0, 11'h030, 8'h11); drv_r(0, 0, 11'h030, 8'h22); #1;
    chk("R4 right busy", r_busy, 1);
    chk("R4 left not busy", l_busy, 0);
    step(); idle();
    rd_l(11'h030, 8'h11, "R4 right write dropped");
  endtask

  task automatic t_rdwr();
    drv_l(0, 0, 11'h030, 8'h77); drv_r(0, 1, 11'h030, '0); #1;
    chk("R10 reader busy", r_busy, 1);
    step();
    chk("R10 read gets old word", r_rdata, 8'h11);
    idle();
    rd_r(11'h030, 8'h77, "R10 left write landed");
  endtask

  task automatic t_incumbent();
    drv_r(0, 0, 11'h040, 8'h55); step(); idle();
    drv_r(0, 1, 11'h040, '0); step();
    drv_l(0, 0, 11'h040, 8'h99); #1;
    chk("R5 newcomer left busy", l_busy, 1);
    chk("R5 incumbent right free", r_busy, 0);
    step();
    chk("R5 incumbent read", r_rdata, 8'h55);
    idle();
    rd_l(11'h040, 8'h55, "R5 newcomer write dropped");
  endtask

  task automatic t_mail();
    drv_l(0, 0, 11'h7FF, 8'h01); step(); idle();
    chk("R6 own write no set", l_int, 0);
    drv_r(0, 0, 11'h7FF, 8'h02); step();
    chk("R6 set by right", l_int, 1);
    chk("R7 untouched", r_int, 0);
    idle();
    drv_l(0, 1, 11'h7FF, '0); step();
    chk("R6 cleared by left read", l_int, 0);
    chk("R6 mailbox data", l_rdata, 8'h02);
    idle();
    drv_l(0, 0, 11'h7FE, 8'h03); step();
    chk("R7 set by left", r_int, 1);
    idle();
    drv_r(0, 1, 11'h7FE, '0); step();
    chk("R7 cleared by right read", r_int, 0);
    chk("R7 mailbox data", r_rdata, 8'h03);
    idle();
  endtask

  task automatic t_slave();
    drv_l(0, 0, 11'h050, 8'h12); step(); idle();
    slave_en = 1; r_busy_in = 1;
    drv_r(0, 0, 11'h050, 8'hEE); #1;
    chk("R8 busy follows input", r_busy, 1);
    step(); idle();
    rd_l(11'h050, 8'h12, "R8 blocked slave write");
    r_busy_in = 0; l_busy_in = 1; #1;
    chk("R8 left busy follows input", l_busy, 1);
    l_busy_in = 0;
    drv_l(0, 0, 11'h050, 8'h34); drv_r(0, 1, 11'h050, '0); #1;
    chk("R8 internal collision ignored", {l_busy, r_busy}, 0);
    step(); idle();
    slave_en = 0;
    rd_r(11'h050, 8'h34, "R8 slave write landed");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_basic();
    t_zero();
    t_rr();
    t_wcol();
    t_rdwr();
    t_incumbent();
    t_mail();
    t_slave();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule